// File: doc/BRIEF.md
# Interval Bottleneck Stall Monitor

This block watches a running core for the resources that hold it back. On every clock it takes one strobe per stall cause and the number of instructions retired in that cycle. It counts the cycles spent stalled on each cause and the total cycles in the current measurement window. A window closes once a fixed number of retired instructions has accumulated. At that point each stall count is compared with a per-cause threshold, expressed as a fraction of the window's cycles. The result is one bottleneck flag per cause.

Thresholds come from a flat bank input that holds one set per core type. The set used is picked by the core-type input in the cycle the window closes. The flags are registered, they hold until the next window closes, and a one-cycle pulse marks each new result. A migration controller outside this block reads the flags. Training of the thresholds and the stall sources themselves live elsewhere.

Top module: `stall_mon`

## Requirements
- R1: While rst_ni is low and after its release, flags_o is all zero and done_o is low until the first window closes.
- R2: A window closes in the cycle where the retired total, including that cycle's retire_cnt_i, reaches WINDOW_INSTR (default 10000). done_o is high for exactly the next cycle. retire_cnt_i values above 8 are taken as 8.
- R3: Instructions retired past the boundary in the closing cycle belong to the closing window, and the next window starts from zero retired. With 7 retired per cycle, windows are therefore 1429 cycles apart.
- R4: Each stall counter adds one for every cycle its stall_i bit is high, and the cycle counter adds one for every cycle. The closing cycle itself is included in both. Stall bit order: 0 branch mispredict, 1 L2 miss, 2 instruction-cache miss, 3 data-cache miss, 4 issue-slot shortage, 5 dispatch blocked by a full queue or buffer.
- R5: flags_o[k] is set when stall_count[k]*256 > threshold[k]*cycle_count, a strict comparison. Equality gives 0.
- R6: threshold[k] is the 8-bit field thr_bank_i[(core_type_i*6+k)*8 +: 8], sampled in the closing cycle.
- R7: flags_o changes only in a cycle where done_o is high.
- R8: All counters clear when a window closes, so no stall or cycle from one window affects the next.
- R9: Counters saturate at 2^CNT_W-1 (default 24 bits) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stall_i | input | 6 | Per-cause stall strobe for this cycle |
| retire_cnt_i | input | 4 | Instructions retired this cycle (0..8) |
| core_type_i | input | 2 | Core type selecting the threshold set |
| thr_bank_i | input | 192 | Thresholds, 8 bits per cause per core type |
| flags_o | output | 6 | Registered bottleneck flags |
| done_o | output | 1 | One-cycle pulse when new flags are loaded |

## Verification
A wrong internal count surfaces only at the next window close. There it shows as a flag that disagrees with the exact fraction, or as a done pulse one or more cycles early or late. The retirement accumulator is the most exposed state: a missed clear or a dropped excess shifts every later done pulse. The bench therefore follows the pulse timing on every clock. Stall patterns that land exactly on a threshold make an off-by-one in the closing-cycle accounting, or a non-strict comparison, flip a flag in the window where it happens.

// File: rtl/stall_mon_pkg.sv
package stall_mon_pkg;
  localparam int CAUSE_NUM = 6;
  localparam int FRAC_SHIFT = 8;

  typedef enum logic [2:0] {
    CAUSE_BR_MISS = 3'd0,
    CAUSE_L2_MISS = 3'd1,
    CAUSE_IC_MISS = 3'd2,
    CAUSE_DC_MISS = 3'd3,
    CAUSE_ISSUE   = 3'd4,
    CAUSE_WINDOW  = 3'd5
  } cause_e;
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] next_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  // value including this cycle's event, used by the closing compare
  assign next_o = (inc_i && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else              cnt_q <= next_o;
  end

  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clear_i) |=> cnt_q == CNT_MAX); // R9
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0); // R8
endmodule

// File: rtl/retire_window.sv
module retire_window #(
  parameter int WINDOW_INSTR = 10000,
  parameter int RET_MAX      = 8,
  parameter int RET_W        = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RET_W-1:0] retire_cnt_i,
  output logic             close_o
);
  localparam int ACC_W = $clog2(WINDOW_INSTR + RET_MAX + 1);

  logic [ACC_W-1:0] acc_q, acc_sum;
  logic [RET_W-1:0] ret_clamped;

  assign ret_clamped = (int'(retire_cnt_i) > RET_MAX) ? RET_W'(RET_MAX) : retire_cnt_i;
  assign acc_sum = acc_q + ACC_W'(ret_clamped);
  assign close_o = (int'(acc_sum) >= WINDOW_INSTR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (close_o) acc_q <= '0;
    else              acc_q <= acc_sum;
  end

  AST_ACC_BELOW_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(acc_q) < WINDOW_INSTR); // R3
endmodule

// File: rtl/threshold_cmp.sv
module threshold_cmp
  import stall_mon_pkg::*;
#(
  parameter int NUM_TYPES = 4,
  parameter int THR_W     = 8,
  parameter int CNT_W     = 24,
  parameter int TYPE_W    = 2
) (
  input  logic [TYPE_W-1:0]                    core_type_i,
  input  logic [NUM_TYPES*CAUSE_NUM*THR_W-1:0] thr_bank_i,
  input  logic [CAUSE_NUM-1:0][CNT_W-1:0]      stall_cnt_i,
  input  logic [CNT_W-1:0]                     cycle_cnt_i,
  output logic [CAUSE_NUM-1:0]                 over_o
);
  localparam int PROD_W = CNT_W + THR_W;

  for (genvar k = 0; k < CAUSE_NUM; k++) begin : g_cause
    logic [THR_W-1:0]  thr;
    logic [PROD_W-1:0] lhs, rhs;
    assign thr = thr_bank_i[(int'(core_type_i)*CAUSE_NUM + k)*THR_W +: THR_W];
    // count * 2^THR_W > t * cycles  <=>  count/cycles > t/2^THR_W
    assign lhs = {stall_cnt_i[k], {THR_W{1'b0}}};
    assign rhs = PROD_W'(thr) * PROD_W'(cycle_cnt_i);
    assign over_o[k] = lhs > rhs;
  end
endmodule

// File: rtl/stall_mon.sv
module stall_mon
  import stall_mon_pkg::*;
#(
  parameter int WINDOW_INSTR = 10000,
  parameter int CNT_W        = 24,
  parameter int THR_W        = 8,
  parameter int NUM_TYPES    = 4,
  parameter int RET_MAX      = 8,
  localparam int RET_W       = $clog2(RET_MAX + 1),
  localparam int TYPE_W      = (NUM_TYPES > 1) ? $clog2(NUM_TYPES) : 1,
  localparam int BANK_W      = NUM_TYPES * CAUSE_NUM * THR_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CAUSE_NUM-1:0] stall_i,
  input  logic [RET_W-1:0]     retire_cnt_i,
  input  logic [TYPE_W-1:0]    core_type_i,
  input  logic [BANK_W-1:0]    thr_bank_i,
  output logic [CAUSE_NUM-1:0] flags_o,
  output logic                 done_o
);
  logic                            close;
  logic [CNT_W-1:0]                cycle_next;
  logic [CAUSE_NUM-1:0][CNT_W-1:0] stall_next;
  logic [CAUSE_NUM-1:0]            over;
  logic [CAUSE_NUM-1:0]            flags_q;
  logic                            done_q;

  retire_window #(
    .WINDOW_INSTR(WINDOW_INSTR), .RET_MAX(RET_MAX), .RET_W(RET_W)
  ) u_window (
    .clk_i(clk_i), .rst_ni(rst_ni), .retire_cnt_i(retire_cnt_i), .close_o(close)
  );

  sat_counter #(.CNT_W(CNT_W)) u_cycle_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(close), .inc_i(1'b1), .next_o(cycle_next)
  );

  for (genvar k = 0; k < CAUSE_NUM; k++) begin : g_stall
    sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(close), .inc_i(stall_i[k]),
      .next_o(stall_next[k])
    );
  end

  threshold_cmp #(
    .NUM_TYPES(NUM_TYPES), .THR_W(THR_W), .CNT_W(CNT_W), .TYPE_W(TYPE_W)
  ) u_cmp (
    .core_type_i(core_type_i), .thr_bank_i(thr_bank_i), .stall_cnt_i(stall_next),
    .cycle_cnt_i(cycle_next), .over_o(over)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= close;
      if (close) flags_q <= over;
    end
  end

  assign flags_o = flags_q;
  assign done_o  = done_q;

  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !close |=> $stable(flags_o)); // R7
  AST_DONE_FOLLOWS_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close |=> done_o); // R2
  AST_NO_STALL_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close && stall_next[0] == '0) |=> !flags_o[0]); // R5

  if (WINDOW_INSTR > 2 * RET_MAX) begin : g_pulse_chk
    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R2
  end
endmodule

// File: tb/stall_mon_tb_top.sv
module stall_mon_tb_top;
  localparam int W      = 10000;
  localparam int CW     = 12;
  localparam int NC     = 6;
  localparam int NT     = 4;
  localparam int CMAX   = (1 << CW) - 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NC-1:0]  stall = '0;
  logic [3:0]     retire = '0;
  logic [1:0]     ctype = '0;
  logic [NT*NC*8-1:0] bank = '0;
  logic [NC-1:0]  flags;
  logic           done;

  always #10 clk = ~clk;

  stall_mon #(.WINDOW_INSTR(W), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .retire_cnt_i(retire),
    .core_type_i(ctype), .thr_bank_i(bank), .flags_o(flags), .done_o(done)
  );

  int errors = 0, checks = 0;
  string tag = "R1";

  task automatic check(input string t, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", t, got, exp, $time);
    end
  endtask

  // behavioural reference
  int m_acc, m_cyc, m_st[NC];
  int exp_flags, exp_done;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_cyc = 0; exp_flags = 0; exp_done = 0;
      foreach (m_st[k]) m_st[k] = 0;
    end else begin
      int r;
      r = (retire > 8) ? 8 : retire;
      m_cyc = (m_cyc < CMAX) ? m_cyc + 1 : CMAX;
      for (int k = 0; k < NC; k++)
        if (stall[k] && m_st[k] < CMAX) m_st[k]++;
      m_acc += r;
      exp_done = 0;
      if (m_acc >= W) begin
        exp_done = 1;
        exp_flags = 0;
        for (int k = 0; k < NC; k++) begin
          longint lhs, rhs;
          lhs = longint'(m_st[k]) * 256;
          rhs = longint'(bank[(ctype*NC + k)*8 +: 8]) * m_cyc;
          if (lhs > rhs) exp_flags |= (1 << k);
        end
        m_acc = 0; m_cyc = 0;
        foreach (m_st[k]) m_st[k] = 0;
      end
    end
  end

  int cyc_no = 0, last_done = -1, prev_done = -1;
  always @(negedge clk) begin
    cyc_no++;
    if (rst_n) begin
      check({tag, " done"}, done, exp_done);
      check({tag, " flags"}, flags, exp_flags);
      if (done) begin prev_done = last_done; last_done = cyc_no; end
    end
  end

  function automatic logic [7:0] thr_of(int ct, int k);
    return 8'((ct * 53 + k * 41 + 30) % 256);
  endfunction

  task automatic load_bank();
    for (int ct = 0; ct < NT; ct++)
      for (int k = 0; k < NC; k++) bank[(ct*NC + k)*8 +: 8] = thr_of(ct, k);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic run_rand(input int n, input int r);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      retire = 4'(r);
      for (int k = 0; k < NC; k++) stall[k] = (($urandom % 100) < (k * 12 + 5));
    end
  endtask

  initial begin
    #5000000;
    errors++; checks++;
    $display("FAIL watchdog: got hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    load_bank();
    repeat (3) @(negedge clk);
    check("R1 reset flags", flags, 0);
    check("R1 reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", done, 0);

    tag = "R4";   // random stalls, full retire rate
    run_rand(3800, 8);

    tag = "R2";   // oversized retire values clamp to 8
    run_rand(2600, 15);

    tag = "R3";
    run_rand(3000, 7);
    check("R3 window period", last_done - prev_done, 1429);

    tag = "R6";   // switch core type every window
    for (int ct = 0; ct < NT; ct++) begin
      ctype = 2'(ct);
      run_rand(1260, 8);
    end

    tag = "R5";   // exact-equality corner
    for (int k = 0; k < NC; k++) bank[k*8 +: 8] = 8'd128;
    ctype = 2'd0;
    wait_done();
    for (int i = 0; i < 1250; i++) begin
      retire = 4'd8;
      stall = {{(NC-1){i[0] == 1'b0}}, 1'b1};
      @(negedge clk);
    end
    check("R5 equality strict", flags, 1);
    check("R5 window done", done, 1);

    tag = "R8";   // quiet window after a busy one
    stall = '0;
    repeat (1300) @(negedge clk);
    check("R8 cleared flags", flags, 0);

    tag = "R9";   // no retirement: counters pin at max
    load_bank();
    retire = 4'd0;
    stall = 6'b000001;
    repeat (4300) @(negedge clk);
    retire = 4'd8;
    wait_done();
    check("R9 saturated flag", flags[0], 1);

    tag = "R7";
    run_rand(2600, 8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule